// File: doc/BRIEF.md
# Sequential Prefetch Stream Buffer

This block sits next to a cache on its miss path. The cache hands it the line address of every miss. The block answers each miss with the line's data. It also keeps a short run of the lines that follow, fetched ahead of need, in a first-in first-out side buffer. These lines stay in the buffer and are not written into the cache array. Instruction lines and data lines go through the same logic; the block does not tell them apart.

On each miss only the oldest buffered line, the head, is compared with the address. If the head matches, its data is returned without a demand access, the buffer advances by one, and one more line is requested: the line after the newest entry. If the head does not match, the whole buffer is dropped. The miss address is then fetched on demand, and the buffer is refilled with the DEPTH lines that follow it. The memory port carries one request at a time. A waiting demand fetch is always chosen over a waiting prefetch.

Top module: `stream_prefetch_buf`

## Requirements
- R1: Every accepted miss produces exactly one response. The response carries the miss line address and the memory data for that address. A miss on an empty buffer, or one that does not match the head, is fetched from memory on demand.
- R2: After a mismatch, the buffer is reloaded with the DEPTH lines that follow the miss address. Their prefetches go out in ascending address order, after the demand fetch.
- R3: When a demand fetch and a prefetch are both waiting for a free memory port, the demand request goes out first.
- R4: A miss that matches the head while the head data is present gets no memory request. Its response is valid in the cycle right after the miss is accepted.
- R5: Each head hit adds one new prefetch, for the line after the newest entry. Over the life of a stream, every line is requested from memory exactly once.
- R6: If a miss matches a head whose prefetch has not returned yet, the block waits for that data. It does not send a second request for the same line.
- R7: Only the head is compared. A miss that matches a later entry is handled as a mismatch and is fetched on demand.
- R8: At most one memory request is outstanding at a time. Once a request is raised, its valid and address hold steady until it is accepted.
- R9: If a prefetch response comes back after its stream was dropped, it is discarded. It never reaches the response port and never fills a new entry.
- R10: Line addresses following the top address wrap to zero, modulo 2^ADDR_W.
- R11: After reset, the miss port is ready, no response is valid, no memory request is raised, and the buffer is empty, so the first miss goes to memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | Cache presents a miss |
| miss_addr | input | ADDR_W | Line address of the miss |
| miss_ready | output | 1 | Block can accept a miss |
| rsp_valid | output | 1 | One-cycle line response |
| rsp_addr | output | ADDR_W | Line address being returned |
| rsp_data | output | DATA_W | Line data being returned |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_addr | output | ADDR_W | Line address requested |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Memory read data valid, in request order |
| mem_rsp_data | input | DATA_W | Memory read data |

## Verification
Assertions check the following on every cycle:
- one response per accepted miss, always for the address last accepted;
- a single outstanding memory request;
- a stable request until it is accepted;
- a waiting demand being raised ahead of any prefetch.

Other behaviour shows only in the bench's scenarios: the ascending refill after a mismatch, the one-line extension per hit, and the rule that the same line is never requested twice within a stream. The same holds for waiting on a pending head, for discarding a prefetch response that arrives after its stream was dropped, and for address wrap. The bench compares the log of memory requests and the returned data with arithmetic expectations, across a sweep of memory latencies and acceptance delays.

// File: rtl/stream_prefetch_buf.sv
module stream_prefetch_buf #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  input  logic [ADDR_W-1:0] miss_addr,
  output logic              miss_ready,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_req_ready,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [1:0] S_IDLE = 2'd0, S_DEM = 2'd1, S_WAIT = 2'd2;

  logic [1:0]        st;
  logic [ADDR_W-1:0] e_addr [DEPTH];
  logic [ADDR_W-1:0] n_addr [DEPTH];
  logic [DATA_W-1:0] e_data [DEPTH];
  logic [DATA_W-1:0] n_data [DEPTH];
  logic [DEPTH-1:0]  e_vld, e_pnd, e_iss, n_vld, n_pnd, n_iss;
  logic [ADDR_W-1:0] dem_addr, req_addr, infl_addr;
  logic              dem_iss, req_act, req_dem, infl, infl_dem;
  logic              acc, head_hit, do_shift, do_flush, dem_need, busy;
  logic              pf_any, pf_take, pf_rsp, pf_hit;
  logic [IW-1:0]     pf_idx;

  assign miss_ready    = (st == S_IDLE);
  assign acc           = miss_valid && miss_ready;
  assign head_hit      = (e_vld[0] || e_pnd[0]) && (e_addr[0] == miss_addr);
  assign do_flush      = acc && !head_hit;
  assign do_shift      = e_vld[0] && ((acc && head_hit) || st == S_WAIT);
  assign dem_need      = (st == S_DEM) && !dem_iss;
  assign busy          = req_act || infl;
  assign pf_take       = !busy && !dem_need && pf_any && !do_shift && !do_flush;
  assign pf_rsp        = mem_rsp_valid && infl && !infl_dem;
  assign mem_req_valid = req_act;
  assign mem_req_addr  = req_addr;

  always_comb begin
    pf_any = 1'b0;
    pf_idx = '0;
    for (int i = DEPTH-1; i >= 0; i--)
      if (e_pnd[i] && !e_iss[i]) begin
        pf_any = 1'b1;
        pf_idx = IW'(i);
      end
  end

  always_comb begin
    n_addr = e_addr;
    n_data = e_data;
    n_vld  = e_vld;
    n_pnd  = e_pnd;
    n_iss  = e_iss;
    pf_hit = 1'b0;
    if (pf_take) n_iss[pf_idx] = 1'b1;
    if (pf_rsp)
      for (int i = 0; i < DEPTH; i++)
        if (!pf_hit && e_pnd[i] && e_iss[i] && e_addr[i] == infl_addr) begin
          pf_hit    = 1'b1;
          n_vld[i]  = 1'b1;
          n_pnd[i]  = 1'b0;
          n_data[i] = mem_rsp_data;
        end
    if (do_shift) begin
      for (int i = 0; i < DEPTH-1; i++) begin
        n_addr[i] = n_addr[i+1];
        n_data[i] = n_data[i+1];
        n_vld[i]  = n_vld[i+1];
        n_pnd[i]  = n_pnd[i+1];
        n_iss[i]  = n_iss[i+1];
      end
      n_addr[DEPTH-1] = e_addr[DEPTH-1] + 1'b1;
      n_vld[DEPTH-1]  = 1'b0;
      n_pnd[DEPTH-1]  = 1'b1;
      n_iss[DEPTH-1]  = 1'b0;
    end else if (do_flush) begin
      for (int i = 0; i < DEPTH; i++)
        n_addr[i] = miss_addr + ADDR_W'(i + 1);
      n_vld = '0;
      n_pnd = '1;
      n_iss = '0;
    end
  end

  always_ff @(posedge clk) begin
    e_addr <= n_addr;
    e_data <= n_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      e_vld     <= '0;
      e_pnd     <= '0;
      e_iss     <= '0;
      rsp_valid <= 1'b0;
      rsp_addr  <= '0;
      rsp_data  <= '0;
      dem_addr  <= '0;
      dem_iss   <= 1'b0;
      req_act   <= 1'b0;
      req_dem   <= 1'b0;
      req_addr  <= '0;
      infl      <= 1'b0;
      infl_dem  <= 1'b0;
      infl_addr <= '0;
    end else begin
      e_vld     <= n_vld;
      e_pnd     <= n_pnd;
      e_iss     <= n_iss;
      rsp_valid <= 1'b0;
      if (req_act && mem_req_ready) begin
        req_act   <= 1'b0;
        infl      <= 1'b1;
        infl_dem  <= req_dem;
        infl_addr <= req_addr;
      end
      if (mem_rsp_valid && infl) infl <= 1'b0;
      if (dem_need && !busy) begin
        req_act  <= 1'b1;
        req_dem  <= 1'b1;
        req_addr <= dem_addr;
        dem_iss  <= 1'b1;
      end else if (pf_take) begin
        req_act  <= 1'b1;
        req_dem  <= 1'b0;
        req_addr <= e_addr[pf_idx];
      end
      case (st)
        S_IDLE:
          if (acc) begin
            if (!head_hit) begin
              st       <= S_DEM;
              dem_addr <= miss_addr;
              dem_iss  <= 1'b0;
            end else if (e_vld[0]) begin
              rsp_valid <= 1'b1;
              rsp_addr  <= miss_addr;
              rsp_data  <= e_data[0];
            end else begin
              st <= S_WAIT;
            end
          end
        S_DEM:
          if (mem_rsp_valid && infl && infl_dem) begin
            st        <= S_IDLE;
            rsp_valid <= 1'b1;
            rsp_addr  <= dem_addr;
            rsp_data  <= mem_rsp_data;
          end
        S_WAIT:
          if (e_vld[0]) begin
            st        <= S_IDLE;
            rsp_valid <= 1'b1;
            rsp_addr  <= e_addr[0];
            rsp_data  <= e_data[0];
          end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/stream_prefetch_buf_chk.sv
module stream_prefetch_buf_chk #(
  parameter int ADDR_W = 16
)(
  input logic              clk,
  input logic              rst_n,
  input logic              miss_valid,
  input logic              miss_ready,
  input logic [ADDR_W-1:0] miss_addr,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] rsp_addr,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_rsp_valid,
  input logic [1:0]        st,
  input logic              dem_iss,
  input logic              infl,
  input logic [ADDR_W-1:0] dem_addr
);
  logic              out_busy, pend;
  logic [ADDR_W-1:0] last_addr;
  logic              taken;

  assign taken = miss_valid && miss_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_busy  <= 1'b0;
      pend      <= 1'b0;
      last_addr <= '0;
    end else begin
      if (mem_req_valid && mem_req_ready) out_busy <= 1'b1;
      else if (mem_rsp_valid)             out_busy <= 1'b0;
      if (taken) begin
        pend      <= 1'b1;
        last_addr <= miss_addr;
      end else if (rsp_valid) begin
        pend <= 1'b0;
      end
    end
  end

  // R8
  single_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready) |-> !out_busy);

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R1
  rsp_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (pend && rsp_addr == last_addr));

  // R1
  one_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    taken |-> (!pend || rsp_valid));

  // R3
  dem_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd1 && !dem_iss && !mem_req_valid && !infl) |=>
      (mem_req_valid && mem_req_addr == dem_addr));
endmodule

bind stream_prefetch_buf stream_prefetch_buf_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_ready(miss_ready),
  .miss_addr(miss_addr), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid), .st(st),
  .dem_iss(dem_iss), .infl(infl), .dem_addr(dem_addr)
);

// File: tb/sim_stream_prefetch_buf.sv
module sim_stream_prefetch_buf;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int DEPTH = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          miss_valid = 1'b0;
  logic [AW-1:0] miss_addr = '0;
  logic          miss_ready, rsp_valid, mem_req_valid;
  logic [AW-1:0] rsp_addr, mem_req_addr;
  logic [DW-1:0] rsp_data;
  logic          mem_req_ready, mem_rsp_valid;
  logic [DW-1:0] mem_rsp_data;

  int total = 0, bad = 0;
  int nreq = 0, lat = 3, rdy_dly = 0;
  logic [AW-1:0] req_log [1024];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stream_prefetch_buf #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_addr(miss_addr),
    .miss_ready(miss_ready), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
    .rsp_data(rsp_data), .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data));

  function automatic logic [DW-1:0] fdat(input logic [AW-1:0] a);
    return {a ^ 16'hA5C3, a};
  endfunction

  function automatic int count_req(input int from, input logic [AW-1:0] a);
    int c = 0;
    for (int i = from; i < nreq; i++) if (req_log[i] == a) c++;
    return c;
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  initial begin
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    forever begin
      @(negedge clk);
      if (rst_n && mem_req_valid) begin
        logic [AW-1:0] a;
        repeat (rdy_dly) @(negedge clk);
        mem_req_ready = 1'b1;
        a = mem_req_addr;
        if (nreq < 1024) req_log[nreq] = a;
        nreq++;
        @(negedge clk);
        mem_req_ready = 1'b0;
        repeat (lat) @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = fdat(a);
        @(negedge clk);
        mem_rsp_valid = 1'b0;
      end
    end
  end

  task automatic do_miss(input logic [AW-1:0] a, input int s, input bit fast, input string rq);
    int t = 0;
    @(negedge clk);
    miss_valid = 1'b1;
    miss_addr  = a;
    while (!miss_ready && t < 500) begin @(negedge clk); t++; end
    @(negedge clk);
    miss_valid = 1'b0;
    t = 0;
    while (!rsp_valid && t < 500) begin @(negedge clk); t++; end
    chk(rsp_valid && rsp_addr == a, rq, "rsp_addr", rsp_addr, a);
    chk(rsp_data == fdat(a), rq, "rsp_data", rsp_data, fdat(a));
    if (fast) chk(t == 0, rq, "hit latency", t, 0);
    chk(count_req(s, a) == 1, rq, "requests for line", count_req(s, a), 1);
  endtask

  task automatic settle();
    repeat (150) @(negedge clk);
  endtask

  task automatic check_seq(input int s, input logic [AW-1:0] base, input int n, input string rq);
    chk(nreq - s == n, rq, "request count", nreq - s, n);
    for (int j = 0; j < n; j++)
      chk(req_log[s+j] == base + AW'(j), rq, "request order", req_log[s+j], base + AW'(j));
  endtask

  initial begin
    repeat (2000 * 100) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(miss_ready == 1'b1, "R11", "miss_ready", miss_ready, 1);
    chk(rsp_valid == 1'b0, "R11", "rsp_valid", rsp_valid, 0);
    chk(mem_req_valid == 1'b0, "R11", "mem_req_valid", mem_req_valid, 0);

    // R1 R2 R3: cold miss, demand first then ascending refill
    s = nreq;
    do_miss(16'h0100, s, 0, "R1");
    settle();
    check_seq(s, 16'h0100, 1 + DEPTH, "R2");
    chk(req_log[s] == 16'h0100, "R3", "first request is demand", req_log[s], 16'h0100);

    // R4 R5: sequential hits, each extends the stream by one line
    for (int k = 1; k <= 3; k++) begin
      do_miss(16'h0100 + AW'(k), s, 1, "R4");
      settle();
    end
    check_seq(s, 16'h0100, 1 + DEPTH + 3, "R5");

    // R7: miss on a non-head entry restarts the stream
    s = nreq;
    do_miss(16'h0106, s, 0, "R7");
    settle();
    check_seq(s, 16'h0106, 1 + DEPTH, "R7");

    // R6: hit on a head still in flight
    lat = 8;
    s = nreq;
    do_miss(16'h2000, s, 0, "R1");
    do_miss(16'h2001, s, 0, "R6");
    settle();

    // R9: stale prefetch response after a flush
    lat = 10;
    do_miss(16'h3000, nreq, 0, "R1");
    s = nreq;
    do_miss(16'h4000, s, 0, "R9");
    do_miss(16'h4001, s, 0, "R9");
    settle();

    // R10: wrap past the top address
    lat = 2;
    s = nreq;
    do_miss(16'hFFFE, s, 0, "R10");
    settle();
    check_seq(s, 16'hFFFE, 1 + DEPTH, "R10");
    do_miss(16'hFFFF, s, 1, "R10");
    do_miss(16'h0000, s, 1, "R10");
    do_miss(16'h0001, s, 1, "R10");
    settle();

    // R2 R5 R8: sweep of latency and acceptance delay, hits back to back
    for (int l = 1; l <= 4; l++)
      for (int r = 0; r <= 2; r++) begin
        logic [AW-1:0] b;
        b = 16'h5000 + AW'(l * 256) + AW'(r * 16);
        lat = l;
        rdy_dly = r;
        s = nreq;
        do_miss(b, s, 0, "R1");
        for (int k = 1; k <= 5; k++) do_miss(b + AW'(k), s, 0, "R5");
        settle();
        check_seq(s, b, 1 + DEPTH + 5, "R2");
      end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule